// File: doc/BRIEF.md
# Two-Side GPIO with Automatic Transmit/Receive Pattern Control

This block drives two 16-pin general purpose banks, one for the receive side of a radio front end and one for the transmit side. Each pin of each bank can be an input (output enable low) or an output. An output pin takes its value from one of four sources: a software-written value, a pattern chosen by the live radio state, or one of two debug buses. Two status inputs, `tx_active` and `rx_active`, select one of four radio states. Each state has its own stored output pattern for each side, so pins can follow the radio as it switches between idle, transmit, receive and full duplex, with no software action.

Software configures the block through a single-cycle register port. Registers are 16 bits wide and sit at even byte offsets. Address bit 0 is ignored. Writes take effect on the clock edge where `reg_we` is high. `reg_rdata` is registered: it shows, one cycle later, the register selected by `reg_addr`. The pins are modelled as split in/out/enable vectors, so that a pad ring can form the tri-state buffers.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After reset every register is 0, so both `pin_oe_*` and `pin_out_*` are 0 and every register reads back as 0.
- R2: The word index `reg_addr[4:1]` selects the register and `reg_addr[0]` is ignored. The index map is: 0 rx io, 1 tx io, 2 rx direction, 3 tx direction, 4 rx select, 5 tx select, 6 rx debug, 7 tx debug. Indices 8 to 15 are the patterns in this order: idle rx, idle tx, in-tx rx, in-tx tx, in-rx rx, in-rx tx, full rx, full tx. Every register other than io reads back the value last written.
- R3: Reading index 0 or 1 returns the sampled levels of `pin_in_rx` or `pin_in_tx`, not the software value written there.
- R4: A direction bit of 1 makes the pin an output (`pin_oe` bit 1). A direction bit of 0 gives `pin_oe` 0 and `pin_out` 0 for that pin, whatever its select and debug bits are.
- R5: With debug bit 0 and select bit 0, an output pin drives the side's software io value.
- R6: With debug bit 0 and select bit 1, an output pin drives the side's pattern for the current radio state.
- R7: The radio state is idle when neither `tx_active` nor `rx_active` is set, in-tx when only `tx_active` is set, in-rx when only `rx_active` is set, and full when both are set.
- R8: With debug bit 1, an output pin drives debug bus 0 when its select bit is 0, and debug bus 1 when its select bit is 1.
- R9: The two sides are independent. Each uses only its own registers, patterns, debug buses and pins.
- R10: `pin_out` and `pin_oe` are registered. A change of a status input, debug bus or register shows at the pins one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address, bit 0 ignored |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| tx_active | input | 1 | Transmitter is active |
| rx_active | input | 1 | Receiver is active |
| dbg0_rx | input | 16 | Debug bus 0, receive side |
| dbg1_rx | input | 16 | Debug bus 1, receive side |
| dbg0_tx | input | 16 | Debug bus 0, transmit side |
| dbg1_tx | input | 16 | Debug bus 1, transmit side |
| pin_in_rx | input | 16 | Pin levels, receive side |
| pin_out_rx | output | 16 | Pin drive values, receive side |
| pin_oe_rx | output | 16 | Pin output enables, receive side |
| pin_in_tx | input | 16 | Pin levels, transmit side |
| pin_out_tx | output | 16 | Pin drive values, transmit side |
| pin_oe_tx | output | 16 | Pin output enables, transmit side |

## Verification
The properties assume that the status inputs, debug buses and register port are synchronous to `clk`. They compare pin outputs with the register and pattern values sampled one edge earlier. The bench drives every input at the falling edge, so each value is stable across the rising edge that samples it. Pin levels on `pin_in_*` are held for several cycles before a read, which covers the sampling flop and the read register.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
    localparam int GPIO_W     = 16;
    localparam int NUM_ST     = 4;
    localparam int ST_W       = $clog2(NUM_ST);
    localparam int NUM_SIDES  = 2;
    localparam int WORD_IDX_W = 4;
    localparam int ADDR_W     = WORD_IDX_W + 1;

    typedef logic [GPIO_W-1:0] word_t;

    // Radio state code is {rx_active, tx_active}
    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 2'd0,
        ST_INTX = 2'd1,
        ST_INRX = 2'd2,
        ST_FULL = 2'd3
    } atr_st_e;

    // Word indices of the register file
    localparam logic [WORD_IDX_W-1:0] IX_IO_RX  = 4'd0;
    localparam logic [WORD_IDX_W-1:0] IX_IO_TX  = 4'd1;
    localparam logic [WORD_IDX_W-1:0] IX_DIR_RX = 4'd2;
    localparam logic [WORD_IDX_W-1:0] IX_DIR_TX = 4'd3;
    localparam logic [WORD_IDX_W-1:0] IX_SEL_RX = 4'd4;
    localparam logic [WORD_IDX_W-1:0] IX_SEL_TX = 4'd5;
    localparam logic [WORD_IDX_W-1:0] IX_DBG_RX = 4'd6;
    localparam logic [WORD_IDX_W-1:0] IX_DBG_TX = 4'd7;

    typedef struct packed {
        word_t io;
        word_t dir;
        word_t sel;
        word_t dbg;
    } side_cfg_t;

    typedef struct packed {
        side_cfg_t               rx;
        side_cfg_t               tx;
        word_t [NUM_ST-1:0]      atr_rx;
        word_t [NUM_ST-1:0]      atr_tx;
    } cfg_t;

    typedef struct packed {
        word_t out;
        word_t oe;
    } pin_drv_t;
endpackage

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
    import gpio_atr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  word_t             pin_in_rx,
    input  word_t             pin_in_tx,
    output cfg_t              cfg,
    output word_t             rdata
);
    typedef struct packed {
        cfg_t  cfg;
        word_t smp_rx;
        word_t smp_tx;
        word_t rdata;
    } regs_st_t;

    regs_st_t s_d, s_q;

    logic [WORD_IDX_W-1:0] idx;
    logic [ST_W-1:0]       pat_st;
    logic                  pat_tx_side;

    assign idx         = addr[ADDR_W-1:1];
    assign pat_st      = idx[ST_W:1];
    assign pat_tx_side = idx[0];

    always_comb begin
        s_d        = s_q;
        s_d.smp_rx = pin_in_rx;
        s_d.smp_tx = pin_in_tx;

        if (we) begin
            unique case (idx)
                IX_IO_RX:  s_d.cfg.rx.io  = wdata;
                IX_IO_TX:  s_d.cfg.tx.io  = wdata;
                IX_DIR_RX: s_d.cfg.rx.dir = wdata;
                IX_DIR_TX: s_d.cfg.tx.dir = wdata;
                IX_SEL_RX: s_d.cfg.rx.sel = wdata;
                IX_SEL_TX: s_d.cfg.tx.sel = wdata;
                IX_DBG_RX: s_d.cfg.rx.dbg = wdata;
                IX_DBG_TX: s_d.cfg.tx.dbg = wdata;
                default: begin
                    if (pat_tx_side) s_d.cfg.atr_tx[pat_st] = wdata;
                    else             s_d.cfg.atr_rx[pat_st] = wdata;
                end
            endcase
        end

        unique case (idx)
            IX_IO_RX:  s_d.rdata = s_q.smp_rx;
            IX_IO_TX:  s_d.rdata = s_q.smp_tx;
            IX_DIR_RX: s_d.rdata = s_q.cfg.rx.dir;
            IX_DIR_TX: s_d.rdata = s_q.cfg.tx.dir;
            IX_SEL_RX: s_d.rdata = s_q.cfg.rx.sel;
            IX_SEL_TX: s_d.rdata = s_q.cfg.tx.sel;
            IX_DBG_RX: s_d.rdata = s_q.cfg.rx.dbg;
            IX_DBG_TX: s_d.rdata = s_q.cfg.tx.dbg;
            default: begin
                if (pat_tx_side) s_d.rdata = s_q.cfg.atr_tx[pat_st];
                else             s_d.rdata = s_q.cfg.atr_rx[pat_st];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg   = s_q.cfg;
    assign rdata = s_q.rdata;
endmodule

// File: rtl/gpio_atr_state.sv
module gpio_atr_state
    import gpio_atr_pkg::*;
(
    input  logic               tx_active,
    input  logic               rx_active,
    input  word_t [NUM_ST-1:0] atr_rx,
    input  word_t [NUM_ST-1:0] atr_tx,
    output word_t              pat_rx,
    output word_t              pat_tx
);
    atr_st_e st;

    always_comb begin
        unique case ({rx_active, tx_active})
            2'b00:   st = ST_IDLE;
            2'b01:   st = ST_INTX;
            2'b10:   st = ST_INRX;
            default: st = ST_FULL;
        endcase
    end

    assign pat_rx = atr_rx[st];
    assign pat_tx = atr_tx[st];
endmodule

// File: rtl/gpio_atr_pinmux.sv
module gpio_atr_pinmux
    import gpio_atr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t dir,
    input  word_t sel,
    input  word_t dbg,
    input  word_t io,
    input  word_t pat,
    input  word_t dbg0,
    input  word_t dbg1,
    output word_t pin_out,
    output word_t pin_oe
);
    word_t    src;
    pin_drv_t drv_d, drv_q;

    for (genvar b = 0; b < GPIO_W; b++) begin : g_bit
        assign src[b] = dbg[b] ? (sel[b] ? dbg1[b] : dbg0[b])
                               : (sel[b] ? pat[b]  : io[b]);
    end

    always_comb begin
        drv_d     = drv_q;
        drv_d.oe  = dir;
        drv_d.out = src & dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign pin_out = drv_q.out;
    assign pin_oe  = drv_q.oe;
endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
    import gpio_atr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [GPIO_W-1:0] reg_wdata,
    output logic [GPIO_W-1:0] reg_rdata,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [GPIO_W-1:0] dbg0_rx,
    input  logic [GPIO_W-1:0] dbg1_rx,
    input  logic [GPIO_W-1:0] dbg0_tx,
    input  logic [GPIO_W-1:0] dbg1_tx,
    input  logic [GPIO_W-1:0] pin_in_rx,
    output logic [GPIO_W-1:0] pin_out_rx,
    output logic [GPIO_W-1:0] pin_oe_rx,
    input  logic [GPIO_W-1:0] pin_in_tx,
    output logic [GPIO_W-1:0] pin_out_tx,
    output logic [GPIO_W-1:0] pin_oe_tx
);
    cfg_t  cfg;
    word_t pat_rx, pat_tx;

    side_cfg_t [NUM_SIDES-1:0] side_cfg;
    word_t     [NUM_SIDES-1:0] side_pat, side_d0, side_d1, side_out, side_oe;

    gpio_atr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pin_in_rx (pin_in_rx),
        .pin_in_tx (pin_in_tx),
        .cfg       (cfg),
        .rdata     (reg_rdata)
    );

    gpio_atr_state u_state (
        .tx_active (tx_active),
        .rx_active (rx_active),
        .atr_rx    (cfg.atr_rx),
        .atr_tx    (cfg.atr_tx),
        .pat_rx    (pat_rx),
        .pat_tx    (pat_tx)
    );

    // Side 0 is the receive bank, side 1 the transmit bank
    assign side_cfg = {cfg.tx, cfg.rx};
    assign side_pat = {pat_tx, pat_rx};
    assign side_d0  = {dbg0_tx, dbg0_rx};
    assign side_d1  = {dbg1_tx, dbg1_rx};

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        gpio_atr_pinmux u_mux (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir     (side_cfg[s].dir),
            .sel     (side_cfg[s].sel),
            .dbg     (side_cfg[s].dbg),
            .io      (side_cfg[s].io),
            .pat     (side_pat[s]),
            .dbg0    (side_d0[s]),
            .dbg1    (side_d1[s]),
            .pin_out (side_out[s]),
            .pin_oe  (side_oe[s])
        );
    end

    assign pin_out_rx = side_out[0];
    assign pin_oe_rx  = side_oe[0];
    assign pin_out_tx = side_out[1];
    assign pin_oe_tx  = side_oe[1];
endmodule

// File: rtl/gpio_atr_chk.sv
module gpio_atr_chk
    import gpio_atr_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  tx_active,
    input logic  rx_active,
    input word_t pin_out_rx,
    input word_t pin_oe_rx,
    input word_t dir_rx,
    input word_t sel_rx,
    input word_t dbg_rx,
    input word_t io_rx,
    input word_t atr_idle_rx,
    input word_t atr_full_rx
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe_rx == '0 && pin_out_rx == '0)); // R1

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pin_oe_rx == $past(dir_rx)); // R4

    AST_NO_DRIVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out_rx & ~pin_oe_rx) == '0); // R4

    AST_SW_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_out_rx ^ $past(io_rx)) & $past(dir_rx & ~sel_rx & ~dbg_rx)) == '0); // R5

    AST_ATR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !rx_active) |=>
        ((pin_out_rx ^ $past(atr_idle_rx)) & $past(dir_rx & sel_rx & ~dbg_rx)) == '0); // R7

    AST_ATR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && rx_active) |=>
        ((pin_out_rx ^ $past(atr_full_rx)) & $past(dir_rx & sel_rx & ~dbg_rx)) == '0); // R6
endmodule

bind gpio_atr_ctrl gpio_atr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_active   (tx_active),
    .rx_active   (rx_active),
    .pin_out_rx  (pin_out_rx),
    .pin_oe_rx   (pin_oe_rx),
    .dir_rx      (cfg.rx.dir),
    .sel_rx      (cfg.rx.sel),
    .dbg_rx      (cfg.rx.dbg),
    .io_rx       (cfg.rx.io),
    .atr_idle_rx (cfg.atr_rx[0]),
    .atr_full_rx (cfg.atr_rx[3])
);

// File: tb/sim_gpio_atr_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_atr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_active = 1'b0, rx_active = 1'b0;
    logic [15:0] dbg0_rx = '0, dbg1_rx = '0, dbg0_tx = '0, dbg1_tx = '0;
    logic [15:0] pin_in_rx = '0, pin_in_tx = '0;
    logic [15:0] pin_out_rx, pin_oe_rx, pin_out_tx, pin_oe_tx;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [4:0] A_IO_RX  = 5'h00, A_IO_TX  = 5'h02;
    localparam logic [4:0] A_DIR_RX = 5'h04, A_DIR_TX = 5'h06;
    localparam logic [4:0] A_SEL_RX = 5'h08, A_SEL_TX = 5'h0A;
    localparam logic [4:0] A_DBG_RX = 5'h0C, A_DBG_TX = 5'h0E;

    always #2.5 clk = ~clk;

    gpio_atr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_active(tx_active), .rx_active(rx_active),
        .dbg0_rx(dbg0_rx), .dbg1_rx(dbg1_rx), .dbg0_tx(dbg0_tx), .dbg1_tx(dbg1_tx),
        .pin_in_rx(pin_in_rx), .pin_out_rx(pin_out_rx), .pin_oe_rx(pin_oe_rx),
        .pin_in_tx(pin_in_tx), .pin_out_tx(pin_out_tx), .pin_oe_tx(pin_oe_tx)
    );

    function automatic logic [4:0] pat_addr(input int st, input int side);
        return 5'(16 + 4 * st + 2 * side);
    endfunction

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 oe_rx", pin_oe_rx, 16'h0);
        check("R1 oe_tx", pin_oe_tx, 16'h0);
        check("R1 out_rx", pin_out_rx, 16'h0);
        check("R1 out_tx", pin_out_tx, 16'h0);
        rd(A_SEL_TX, v);       check("R1 sel_tx read", v, 16'h0);
        rd(pat_addr(3, 1), v); check("R1 full tx pattern read", v, 16'h0);
    endtask

    task automatic t_readback();
        logic [15:0] v;
        wr(A_SEL_TX, 16'h1234);       rd(A_SEL_TX, v);       check("R2 sel_tx", v, 16'h1234);
        wr(pat_addr(3, 1), 16'hBEEF); rd(5'h1F, v);          check("R2 full tx via odd addr", v, 16'hBEEF);
        wr(5'h07, 16'h00F0);          rd(A_DIR_TX, v);       check("R2 odd write dir_tx", v, 16'h00F0);
        wr(pat_addr(1, 0), 16'hC001); rd(pat_addr(1, 0), v); check("R2 in-tx rx pattern", v, 16'hC001);
        rd(pat_addr(2, 0), v);        check("R2 in-rx rx untouched", v, 16'h0000);
        wr(A_DBG_RX, 16'h8001);       rd(A_DBG_RX, v);       check("R2 dbg_rx", v, 16'h8001);
        wr(A_DBG_RX, 16'h0000); wr(A_DIR_TX, 16'h0000); wr(A_SEL_TX, 16'h0000);
        wr(pat_addr(1, 0), 16'h0000); wr(pat_addr(3, 1), 16'h0000);
    endtask

    task automatic t_io_read();
        logic [15:0] v;
        wr(A_IO_RX, 16'hFFFF);
        @(negedge clk); pin_in_rx = 16'h3C3C; pin_in_tx = 16'h0FF0;
        settle();
        rd(A_IO_RX, v); check("R3 io_rx reads pins", v, 16'h3C3C);
        rd(A_IO_TX, v); check("R3 io_tx reads pins", v, 16'h0FF0);
    endtask

    task automatic t_dir();
        wr(A_IO_RX, 16'hFFFF); wr(A_SEL_RX, 16'h0F0F); wr(A_DBG_RX, 16'h3333);
        dbg0_rx = 16'hFFFF; dbg1_rx = 16'hFFFF;
        wr(pat_addr(0, 0), 16'hFFFF);
        wr(A_DIR_RX, 16'h00FF); settle();
        check("R4 oe_rx", pin_oe_rx, 16'h00FF);
        check("R4 out_rx masked by dir", pin_out_rx, 16'h00FF);
        wr(A_SEL_RX, 16'h0000); wr(A_DBG_RX, 16'h0000);
        dbg0_rx = '0; dbg1_rx = '0; wr(pat_addr(0, 0), 16'h0000);
    endtask

    task automatic t_sw();
        wr(A_DIR_RX, 16'hFFFF); wr(A_IO_RX, 16'h1234); settle();
        check("R5 sw value", pin_out_rx, 16'h1234);
        wr(A_IO_RX, 16'hA50F); settle();
        check("R5 sw value 2", pin_out_rx, 16'hA50F);
    endtask

    task automatic t_atr();
        logic [15:0] pats [4] = '{16'h1111, 16'h2222, 16'h4444, 16'h8888};
        for (int s = 0; s < 4; s++) wr(pat_addr(s, 0), pats[s]);
        wr(A_SEL_RX, 16'hFFFF);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); tx_active = s[0]; rx_active = s[1];
            settle();
            check($sformatf("R7 R6 state %0d pattern", s), pin_out_rx, pats[s]);
        end
        wr(A_SEL_RX, 16'hFF00); wr(A_IO_RX, 16'h00CC);
        @(negedge clk); tx_active = 1'b1; rx_active = 1'b0; settle();
        check("R6 mixed select in-tx", pin_out_rx, 16'h22CC);
        @(negedge clk); tx_active = 1'b0; rx_active = 1'b0; settle();
    endtask

    task automatic t_debug();
        dbg0_rx = 16'hAAAA; dbg1_rx = 16'h5555;
        wr(A_DBG_RX, 16'hFFFF); wr(A_SEL_RX, 16'h0F0F); settle();
        check("R8 debug buses by select", pin_out_rx, 16'hA5A5);
        wr(A_DBG_RX, 16'h00FF); wr(A_SEL_RX, 16'h0000); wr(A_IO_RX, 16'h1200); settle();
        check("R8 debug low half, sw high half", pin_out_rx, 16'h12AA);
        @(negedge clk); dbg0_rx = 16'h0055; settle();
        check("R8 debug bus 0 follows live value", pin_out_rx, 16'h1255);
        wr(A_DBG_RX, 16'h0000);
    endtask

    task automatic t_sides();
        dbg0_tx = 16'hFFFF; dbg1_tx = 16'hFFFF;
        wr(A_DIR_TX, 16'hFFFF); wr(A_IO_TX, 16'h6789); settle();
        check("R9 tx sw value", pin_out_tx, 16'h6789);
        check("R9 rx unchanged by tx writes", pin_out_rx, 16'h1200);
        wr(pat_addr(0, 1), 16'h0F0F); wr(A_SEL_TX, 16'hFFFF); settle();
        check("R9 tx idle pattern own", pin_out_tx, 16'h0F0F);
        wr(A_SEL_RX, 16'hFFFF); settle();
        check("R9 rx idle pattern own", pin_out_rx, 16'h1111);
    endtask

    task automatic t_latency();
        @(negedge clk); tx_active = 1'b1; rx_active = 1'b1;
        #1;
        check("R10 before edge old pattern", pin_out_rx, 16'h1111);
        @(negedge clk);
        check("R10 one edge later full pattern", pin_out_rx, 16'h8888);
        @(negedge clk); reg_we = 1'b1; reg_addr = A_DIR_RX; reg_wdata = 16'h0001;
        @(negedge clk); reg_we = 1'b0;
        check("R10 dir write not yet at pins", pin_oe_rx, 16'hFFFF);
        @(negedge clk);
        check("R10 dir write at pins", pin_oe_rx, 16'h0001);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_io_read();
        t_dir();
        t_sw();
        t_atr();
        t_debug();
        t_sides();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule